// File: doc/BRIEF.md
# E1 Timeslot-0 Spare Bit Host Access

This block sits beside an E1 framer and gives a host processor access to the international (Si) and national (Sa) bits carried in timeslot 0. The framer supplies per-bit strobes for both directions. Each strobe comes with a timeslot-0 marker, the bit position inside the timeslot, and a flag that tells the alignment frame (FAS) from the non-alignment frame (NAF). Frame alignment search, CRC-4 computation and E-bit generation happen elsewhere.

On receive, the block collects the eight timeslot-0 bits of each FAS and NAF. At the end of every NAF timeslot 0 it copies both bytes into two host-readable registers and raises a sticky receive event flag. The host then has one double frame (250 µs) to read them. On transmit, the block samples two host-written bytes at the first timeslot-0 bit of every FAS and raises a sticky transmit event flag. It then inserts those bytes into the outgoing timeslot 0. Mode controls can take the Si position, or single Sa positions, from the serial transmit stream instead of the host bytes. Bits outside timeslot 0 pass straight through.

Top module: `e1_ts0_spare_access`

## Requirements
- R1: After reset, both receive registers read zero, both event flags are clear and the transmit output is zero.
- R2: When bit 8 of a NAF timeslot 0 is strobed, the receive registers take the bits of the latest FAS and NAF timeslot 0. Bit 1 is stored in the register MSB and bit 8 in the LSB. The new values are visible after that clock edge.
- R3: The receive event flag is set on the same edge as the R2 update. It stays set until a receive-clear pulse, and a set in the same cycle as a clear wins.
- R4: Between R2 update events the receive registers do not change. In particular, a FAS timeslot 0 on its own leaves them untouched.
- R5: The host transmit bytes are sampled only at the bit-1 strobe of a FAS timeslot 0, and that strobe sets the sticky transmit event flag. A change to the host bytes at any other time has no effect until the next such strobe.
- R6: For a timeslot-0 strobe at position p (0 = bit 1), the transmit output one edge later carries bit 7-p of the sampled FAS or NAF byte, unless R8 or R9 applies. Between strobes the output holds its value.
- R7: For a strobe outside timeslot 0, the transmit output one edge later equals the serial transmit input.
- R8: At position 0 of either frame, the output takes the serial transmit input when any of Si-from-serial, CRC-4 mode or automatic E-bit is set.
- R9: Sa control bit i (0..4) selects Sa(4+i), which is NAF position 3+i. When that bit is set, that NAF position takes the serial transmit input. Sa controls have no effect in the FAS.
- R10: The transmit event flag stays set until a transmit-clear pulse. A NAF strobe does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit_en | input | 1 | Receive bit strobe |
| rx_ts0 | input | 1 | Current receive bit lies in timeslot 0 |
| rx_naf | input | 1 | Receive frame is a NAF (0 = FAS) |
| rx_pos | input | 3 | Receive bit position in timeslot (0 = bit 1) |
| rx_data | input | 1 | Serial receive data |
| rx_flag_clr | input | 1 | Clears the receive event flag |
| rx_fas_byte | output | 8 | Latest FAS timeslot-0 byte |
| rx_naf_byte | output | 8 | Latest NAF timeslot-0 byte |
| rx_flag | output | 1 | Sticky receive event flag |
| tx_bit_en | input | 1 | Transmit bit strobe |
| tx_ts0 | input | 1 | Current transmit bit lies in timeslot 0 |
| tx_naf | input | 1 | Transmit frame is a NAF (0 = FAS) |
| tx_pos | input | 3 | Transmit bit position in timeslot (0 = bit 1) |
| tx_ser | input | 1 | Serial transmit data |
| host_fas | input | 8 | Host byte for FAS timeslot 0 |
| host_naf | input | 8 | Host byte for NAF timeslot 0 |
| si_from_ser | input | 1 | Take Si from the serial input |
| crc4_en | input | 1 | CRC-4 mode enabled (Si overridden) |
| ebit_auto | input | 1 | Automatic E-bit insertion (Si overridden) |
| sa_from_ser | input | 5 | Per-bit serial source for Sa4..Sa8 |
| tx_flag_clr | input | 1 | Clears the transmit event flag |
| tx_out | output | 1 | Transmit data after insertion |
| tx_flag | output | 1 | Sticky transmit event flag |

## Verification
The insertion path is driven from a table that covers FAS and NAF positions with no overrides, each of the three Si override sources, and single Sa controls. Between them these cases separate a register bit from a serial bit at every decision point. Other rows set Sa controls during a FAS, or an Si source at a position other than 0, to show that each override acts only on its own position. Directed sequences check the receive side. A full double frame is sent with a distinct byte per frame, so that a swapped or reversed capture is detected. A lone FAS follows, to show the registers wait for the NAF. A host byte change without a FAS sample point shows that stale values are sent again.

// File: rtl/e1ts0_pkg.sv
package e1ts0_pkg;
  localparam int TS0_BITS_DEF  = 8;
  localparam int SA_COUNT_DEF  = 5;
  localparam int SA_FIRST_DEF  = 3;

  typedef enum logic {
    FRM_ALIGN    = 1'b0,
    FRM_NONALIGN = 1'b1
  } frame_kind_e;
endpackage

// File: rtl/ts0_event_flag.sv
module ts0_event_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // R3 and R10: set wins, flag sticky otherwise
  assert_flag_set_R3: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/ts0_rx_capture.sv
module ts0_rx_capture #(
  parameter int TS_BITS = e1ts0_pkg::TS0_BITS_DEF,
  localparam int POS_W = $clog2(TS_BITS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_en,
  input  logic               in_ts0,
  input  logic               is_naf,
  input  logic [POS_W-1:0]   pos,
  input  logic               data,
  output logic [TS_BITS-1:0] fas_q,
  output logic [TS_BITS-1:0] naf_q,
  output logic               upd_o
);
  import e1ts0_pkg::*;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(TS_BITS - 1);

  logic [TS_BITS-1:0] fas_stage, naf_stage;
  logic [POS_W-1:0]   idx;
  logic               hit;

  assign idx   = LAST_POS - pos;
  assign hit   = bit_en && in_ts0;
  assign upd_o = hit && (is_naf == FRM_NONALIGN) && (pos == LAST_POS);

  always_ff @(posedge clk) begin
    if (rst) begin
      fas_stage <= '0;
      naf_stage <= '0;
    end else if (hit) begin
      if (is_naf == FRM_NONALIGN) naf_stage[idx] <= data;
      else                        fas_stage[idx] <= data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fas_q <= '0;
      naf_q <= '0;
    end else if (upd_o) begin
      fas_q <= fas_stage;
      naf_q <= {naf_stage[TS_BITS-1:1], data};
    end
  end

  assert_rx_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !upd_o |=> ($stable(fas_q) && $stable(naf_q)));
  assert_rx_last_bit_R2: assert property (@(posedge clk) disable iff (rst)
    upd_o |=> (naf_q[0] == $past(data)));
endmodule

// File: rtl/ts0_tx_insert.sv
module ts0_tx_insert #(
  parameter int TS_BITS  = e1ts0_pkg::TS0_BITS_DEF,
  parameter int SA_COUNT = e1ts0_pkg::SA_COUNT_DEF,
  parameter int SA_FIRST = e1ts0_pkg::SA_FIRST_DEF,
  localparam int POS_W = $clog2(TS_BITS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_en,
  input  logic                in_ts0,
  input  logic                is_naf,
  input  logic [POS_W-1:0]    pos,
  input  logic                ser,
  input  logic [TS_BITS-1:0]  host_fas,
  input  logic [TS_BITS-1:0]  host_naf,
  input  logic                si_from_ser,
  input  logic                crc4_en,
  input  logic                ebit_auto,
  input  logic [SA_COUNT-1:0] sa_from_ser,
  output logic                out_bit,
  output logic                sample_o
);
  import e1ts0_pkg::*;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(TS_BITS - 1);

  logic [TS_BITS-1:0]  work_fas, work_naf, cur_fas;
  logic [POS_W-1:0]    idx;
  logic [SA_COUNT-1:0] sa_hit;
  logic                si_ovr, reg_bit, next_bit;

  assign sample_o = bit_en && in_ts0 && (is_naf == FRM_ALIGN) && (pos == '0);
  assign cur_fas  = sample_o ? host_fas : work_fas;
  assign idx      = LAST_POS - pos;
  assign reg_bit  = (is_naf == FRM_NONALIGN) ? work_naf[idx] : cur_fas[idx];
  assign si_ovr   = (pos == '0) && (si_from_ser || crc4_en || ebit_auto);

  for (genvar i = 0; i < SA_COUNT; i++) begin : g_sa
    assign sa_hit[i] = (is_naf == FRM_NONALIGN) && sa_from_ser[i] &&
                       (pos == POS_W'(SA_FIRST + i));
  end

  always_comb begin
    if (!in_ts0)                 next_bit = ser;
    else if (si_ovr || |sa_hit)  next_bit = ser;
    else                         next_bit = reg_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      work_fas <= '0;
      work_naf <= '0;
    end else if (sample_o) begin
      work_fas <= host_fas;
      work_naf <= host_naf;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         out_bit <= 1'b0;
    else if (bit_en) out_bit <= next_bit;
  end

  assert_passthru_R7: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !in_ts0) |=> (out_bit == $past(ser)));
  assert_si_override_R8: assert property (@(posedge clk) disable iff (rst)
    (bit_en && in_ts0 && pos == '0 && (si_from_ser || crc4_en || ebit_auto))
      |=> (out_bit == $past(ser)));
  assert_out_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(out_bit));
  assert_sample_only_fas_R5: assert property (@(posedge clk) disable iff (rst)
    !sample_o |=> ($stable(work_fas) && $stable(work_naf)));
endmodule

// File: rtl/e1_ts0_spare_access.sv
module e1_ts0_spare_access #(
  parameter int TS_BITS  = e1ts0_pkg::TS0_BITS_DEF,
  parameter int SA_COUNT = e1ts0_pkg::SA_COUNT_DEF,
  parameter int SA_FIRST = e1ts0_pkg::SA_FIRST_DEF,
  localparam int POS_W = $clog2(TS_BITS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_bit_en,
  input  logic                rx_ts0,
  input  logic                rx_naf,
  input  logic [POS_W-1:0]    rx_pos,
  input  logic                rx_data,
  input  logic                rx_flag_clr,
  output logic [TS_BITS-1:0]  rx_fas_byte,
  output logic [TS_BITS-1:0]  rx_naf_byte,
  output logic                rx_flag,
  input  logic                tx_bit_en,
  input  logic                tx_ts0,
  input  logic                tx_naf,
  input  logic [POS_W-1:0]    tx_pos,
  input  logic                tx_ser,
  input  logic [TS_BITS-1:0]  host_fas,
  input  logic [TS_BITS-1:0]  host_naf,
  input  logic                si_from_ser,
  input  logic                crc4_en,
  input  logic                ebit_auto,
  input  logic [SA_COUNT-1:0] sa_from_ser,
  input  logic                tx_flag_clr,
  output logic                tx_out,
  output logic                tx_flag
);
  logic rx_upd, tx_sample;

  ts0_rx_capture #(.TS_BITS(TS_BITS)) u_rx (
    .clk(clk), .rst(rst), .bit_en(rx_bit_en), .in_ts0(rx_ts0),
    .is_naf(rx_naf), .pos(rx_pos), .data(rx_data),
    .fas_q(rx_fas_byte), .naf_q(rx_naf_byte), .upd_o(rx_upd)
  );

  ts0_event_flag u_rx_flag (
    .clk(clk), .rst(rst), .set_i(rx_upd), .clr_i(rx_flag_clr), .flag_o(rx_flag)
  );

  ts0_tx_insert #(.TS_BITS(TS_BITS), .SA_COUNT(SA_COUNT), .SA_FIRST(SA_FIRST)) u_tx (
    .clk(clk), .rst(rst), .bit_en(tx_bit_en), .in_ts0(tx_ts0),
    .is_naf(tx_naf), .pos(tx_pos), .ser(tx_ser),
    .host_fas(host_fas), .host_naf(host_naf),
    .si_from_ser(si_from_ser), .crc4_en(crc4_en), .ebit_auto(ebit_auto),
    .sa_from_ser(sa_from_ser), .out_bit(tx_out), .sample_o(tx_sample)
  );

  ts0_event_flag u_tx_flag (
    .clk(clk), .rst(rst), .set_i(tx_sample), .clr_i(tx_flag_clr), .flag_o(tx_flag)
  );

  assert_rx_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (rx_bit_en && rx_ts0 && rx_naf && rx_pos == POS_W'(TS_BITS - 1)) |=> rx_flag);
  assert_tx_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (tx_bit_en && tx_ts0 && !tx_naf && tx_pos == '0) |=> tx_flag);
endmodule

// File: tb/tb_e1_ts0_spare_access.sv
module tb_e1_ts0_spare_access;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_bit_en = 0, rx_ts0 = 0, rx_naf = 0, rx_data = 0, rx_flag_clr = 0;
  logic [2:0] rx_pos = '0;
  logic [7:0] rx_fas_byte, rx_naf_byte;
  logic rx_flag;
  logic tx_bit_en = 0, tx_ts0 = 0, tx_naf = 0, tx_ser = 0, tx_flag_clr = 0;
  logic [2:0] tx_pos = '0;
  logic [7:0] host_fas = 8'h9B, host_naf = 8'h56;
  logic si_from_ser = 0, crc4_en = 0, ebit_auto = 0;
  logic [4:0] sa_from_ser = '0;
  logic tx_out, tx_flag;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  e1_ts0_spare_access dut (
    .clk(clk), .rst(rst),
    .rx_bit_en(rx_bit_en), .rx_ts0(rx_ts0), .rx_naf(rx_naf), .rx_pos(rx_pos),
    .rx_data(rx_data), .rx_flag_clr(rx_flag_clr),
    .rx_fas_byte(rx_fas_byte), .rx_naf_byte(rx_naf_byte), .rx_flag(rx_flag),
    .tx_bit_en(tx_bit_en), .tx_ts0(tx_ts0), .tx_naf(tx_naf), .tx_pos(tx_pos),
    .tx_ser(tx_ser), .host_fas(host_fas), .host_naf(host_naf),
    .si_from_ser(si_from_ser), .crc4_en(crc4_en), .ebit_auto(ebit_auto),
    .sa_from_ser(sa_from_ser), .tx_flag_clr(tx_flag_clr),
    .tx_out(tx_out), .tx_flag(tx_flag)
  );

  // {naf, pos[2:0], si, crc, ebit, sa[4:0], ser, expected}
  // host bytes: FAS 8'h9B, NAF 8'h56
  localparam logic [13:0] TV [14] = '{
    {1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 5'b00000, 1'b0, 1'b1}, // R6 FAS bit1
    {1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 5'b00000, 1'b1, 1'b0}, // R6
    {1'b0, 3'd7, 1'b0, 1'b0, 1'b0, 5'b00000, 1'b0, 1'b1}, // R6
    {1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 5'b00000, 1'b1, 1'b0}, // R6 NAF
    {1'b1, 3'd3, 1'b0, 1'b0, 1'b0, 5'b00000, 1'b0, 1'b1}, // R6
    {1'b1, 3'd7, 1'b0, 1'b0, 1'b0, 5'b00000, 1'b1, 1'b0}, // R6
    {1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 5'b00000, 1'b0, 1'b0}, // R8 si
    {1'b1, 3'd0, 1'b0, 1'b1, 1'b0, 5'b00000, 1'b1, 1'b1}, // R8 crc
    {1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 5'b00000, 1'b1, 1'b1}, // R8 ebit
    {1'b1, 3'd3, 1'b0, 1'b0, 1'b0, 5'b00001, 1'b0, 1'b0}, // R9 Sa4
    {1'b1, 3'd7, 1'b0, 1'b0, 1'b0, 5'b10000, 1'b1, 1'b1}, // R9 Sa8
    {1'b1, 3'd5, 1'b0, 1'b0, 1'b0, 5'b00001, 1'b0, 1'b1}, // R9 other pos
    {1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 5'b11111, 1'b0, 1'b1}, // R9 FAS no effect
    {1'b0, 3'd2, 1'b1, 1'b0, 1'b0, 5'b00000, 1'b1, 1'b0}  // R8 only pos 0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tx_step(input logic ts0, input logic naf, input logic [2:0] pos,
                         input logic ser);
    @(negedge clk);
    tx_bit_en = 1; tx_ts0 = ts0; tx_naf = naf; tx_pos = pos; tx_ser = ser;
    @(negedge clk);
    tx_bit_en = 0;
  endtask

  task automatic rx_frame(input logic naf, input logic [7:0] b);
    for (int p = 0; p < 8; p++) begin
      @(negedge clk);
      rx_bit_en = 1; rx_ts0 = 1; rx_naf = naf; rx_pos = 3'(p); rx_data = b[7-p];
    end
    @(negedge clk);
    rx_bit_en = 0;
  endtask

  task automatic pulse_clr(input bit rxside);
    @(negedge clk);
    if (rxside) rx_flag_clr = 1; else tx_flag_clr = 1;
    @(negedge clk);
    rx_flag_clr = 0; tx_flag_clr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 rx_fas_byte", rx_fas_byte, 0);
    check("R1 rx_naf_byte", rx_naf_byte, 0);
    check("R1 flags", {rx_flag, tx_flag}, 0);
    check("R1 tx_out", tx_out, 0);

    // receive: full double frame
    rx_frame(1'b0, 8'h9B);
    check("R4 rx after FAS only", rx_fas_byte, 0);
    check("R3 no flag before NAF", rx_flag, 0);
    rx_frame(1'b1, 8'h5F);
    check("R2 rx fas byte", rx_fas_byte, 8'h9B);
    check("R2 rx naf byte", rx_naf_byte, 8'h5F);
    check("R3 rx flag set", rx_flag, 1);
    repeat (3) @(negedge clk);
    check("R3 rx flag sticky", rx_flag, 1);
    pulse_clr(1'b1);
    check("R3 rx flag cleared", rx_flag, 0);
    rx_frame(1'b0, 8'h1B);
    check("R4 fas held", rx_fas_byte, 8'h9B);
    check("R4 naf held", rx_naf_byte, 8'h5F);
    rx_frame(1'b1, 8'h40);
    check("R2 second fas", rx_fas_byte, 8'h1B);
    check("R2 second naf", rx_naf_byte, 8'h40);

    // transmit: table
    for (int i = 0; i < 14; i++) begin
      si_from_ser = TV[i][9]; crc4_en = TV[i][8]; ebit_auto = TV[i][7];
      sa_from_ser = TV[i][6:2];
      tx_step(1'b1, TV[i][13], TV[i][12:10], TV[i][1]);
      check($sformatf("R6/R8/R9 vector %0d", i), tx_out, TV[i][0]);
    end
    si_from_ser = 0; crc4_en = 0; ebit_auto = 0; sa_from_ser = '0;

    check("R5 tx flag set", tx_flag, 1);
    pulse_clr(1'b0);
    check("R10 tx flag cleared", tx_flag, 0);
    tx_step(1'b1, 1'b1, 3'd1, 1'b0);
    check("R10 NAF keeps flag clear", tx_flag, 0);

    // stale data resent until next FAS sample point
    host_naf = 8'hA9;
    tx_step(1'b1, 1'b1, 3'd0, 1'b0);
    check("R5 old naf resent", tx_out, 0);
    repeat (2) @(negedge clk);
    check("R6 output holds without strobe", tx_out, 0);
    tx_step(1'b1, 1'b0, 3'd0, 1'b0);
    check("R5 tx flag on sample", tx_flag, 1);
    tx_step(1'b1, 1'b1, 3'd0, 1'b0);
    check("R5 new naf used", tx_out, 1);

    // outside timeslot 0
    tx_step(1'b0, 1'b1, 3'd0, 1'b1);
    check("R7 passthru one", tx_out, 1);
    tx_step(1'b0, 1'b0, 3'd0, 1'b0);
    check("R7 passthru zero", tx_out, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule